// File: doc/BRIEF.md
# Block-Wide Thread Compactor

The compactor takes one active-thread mask covering a whole thread block, together with the program counter of the path those threads follow, and turns it into a short stream of dense warps. Every thread is tied to a fixed SIMD lane: lane = thread ID mod `LANES`, row = thread ID div `LANES`. Threads never change lane. Each lane has its own pending set and its own priority encoder. For every warp emitted, each encoder selects the lowest-numbered thread still pending in its lane, or marks its slot empty when the lane has nothing left. The number of warps emitted therefore equals the largest count of active threads found in any one lane. When the mask is full, the warps come out exactly as the static arrangement, row by row.

Control is a three-state machine. `ST_IDLE` accepts a mask. On acceptance it takes transition IDLE->EMIT when the mask is non-zero, or IDLE->NULL when the mask is all zero. `ST_EMIT` presents one warp per cycle under a valid/ready handshake. It stays in EMIT while warps remain and takes EMIT->IDLE when the final warp is accepted. `ST_NULL` lasts one cycle, pulses `done` without emitting a warp, and takes NULL->IDLE. The `done` output is high together with the final warp, or alone in `ST_NULL`.

Top module: `blk_thread_compactor`

## Requirements
- R1: After reset `in_ready` is 1, and `out_valid` and `done` are 0.
- R2: A thread ID presented in output slot l always satisfies ID mod `LANES` == l. Thread IDs are 0-based; bit t of `in_mask` is thread t; slot l is `out_tid[l*TIDW +: TIDW]`.
- R3: In each warp, every lane carries the lowest-numbered thread of that lane not yet emitted, so within a lane the IDs rise from warp to warp.
- R4: The number of warps emitted for a mask equals the maximum, over all lanes, of the number of active threads in that lane.
- R5: A lane with no pending thread shows `out_lane_vld[l]`=0. Every emitted warp has at least one valid lane.
- R6: While `out_valid` is 1 and `out_ready` is 0, the warp on the outputs is held unchanged.
- R7: `done` is 1 together with the final warp of a mask and 0 with every earlier warp. After the final warp is accepted, `out_valid` drops the next cycle.
- R8: An all-zero mask produces no warp. `done` is 1 for exactly the one cycle after acceptance, and the block is then ready again.
- R9: A full mask yields `ROWS` warps in which warp w, slot l carries thread w*`LANES`+l, with all lanes valid.
- R10: `in_ready` is 0 while warps are being emitted, and a mask offered then is not taken and does not disturb the warps in flight.
- R11: Every warp of a mask carries on `out_pc` the value sampled on `in_pc` when that mask was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A mask and PC are offered |
| in_ready | output | 1 | The block can accept a mask (idle) |
| in_mask | input | LANES*ROWS | Block-wide active-thread mask; bit t is thread t |
| in_pc | input | PCW | Program counter of the path |
| out_valid | output | 1 | A compacted warp is presented |
| out_ready | input | 1 | The consumer takes the warp |
| out_pc | output | PCW | PC of the warp |
| out_tid | output | LANES*TIDW | Thread ID per lane slot |
| out_lane_vld | output | LANES | Slot holds a thread |
| done | output | 1 | Final warp of the mask, or an empty mask finished |

## Verification
The hardest condition to reach from the ports is a final warp that is stalled while a new mask is already waiting on the input. In that situation the handshake, the `done` timing and the refusal of the new mask all interact. The stimulus reaches it by holding a second mask on `in_valid` throughout a run while `out_ready` is withdrawn at random. A lane-heavy mask, where only one lane has three threads, gives the longest run with mostly empty slots.

// File: rtl/tc_pkg.sv
package tc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_NULL = 2'd2
    } tc_state_e;
endpackage

// File: rtl/tc_penc.sv
// Lowest-index-first priority encoder with a one-hot grant.
module tc_penc #(
    parameter int W = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  grant
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
                grant = W'(1) << i;
            end
        end
    end
endmodule

// File: rtl/tc_lane.sv
// One lane: pending row set, encoder and thread-ID formation.
module tc_lane #(
    parameter int ROWS  = 3,
    parameter int LANES = 4,
    parameter int LANE  = 0,
    parameter int TIDW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [ROWS-1:0] load_bits,
    input  logic            advance,
    output logic            pick_vld,
    output logic [TIDW-1:0] pick_tid,
    output logic            left_empty
);
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam logic [TIDW-1:0] LANE_T  = TIDW'(LANE);
    localparam logic [TIDW-1:0] LANES_T = TIDW'(LANES);

    logic [ROWS-1:0] pend_q;
    logic [ROWS-1:0] grant;
    logic [RW-1:0]   row;

    tc_penc #(.W(ROWS)) u_penc (
        .req   (pend_q),
        .found (pick_vld),
        .idx   (row),
        .grant (grant)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= '0;
        else if (load)    pend_q <= load_bits;
        else if (advance) pend_q <= pend_q & ~grant;
    end

    assign pick_tid   = TIDW'(row) * LANES_T + LANE_T;
    assign left_empty = ((pend_q & ~grant) == '0);
endmodule

// File: rtl/blk_thread_compactor.sv
module blk_thread_compactor #(
    parameter int LANES = 4,
    parameter int ROWS  = 3,
    parameter int PCW   = 32,
    localparam int NTHR = LANES * ROWS,
    localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [NTHR-1:0]       in_mask,
    input  logic [PCW-1:0]        in_pc,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [PCW-1:0]        out_pc,
    output logic [LANES*TIDW-1:0] out_tid,
    output logic [LANES-1:0]      out_lane_vld,
    output logic                  done
);
    import tc_pkg::*;

    tc_state_e       state_q, state_nx;
    logic            load, advance, last_warp;
    logic [LANES-1:0] lane_empty;
    logic [PCW-1:0]  pc_q;

    genvar l, r;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            logic [ROWS-1:0] bits;
            for (r = 0; r < ROWS; r++) begin : g_row
                assign bits[r] = in_mask[r*LANES + l];
            end
            tc_lane #(.ROWS(ROWS), .LANES(LANES), .LANE(l), .TIDW(TIDW)) u_lane (
                .clk        (clk),
                .rst_n      (rst_n),
                .load       (load),
                .load_bits  (bits),
                .advance    (advance),
                .pick_vld   (out_lane_vld[l]),
                .pick_tid   (out_tid[l*TIDW +: TIDW]),
                .left_empty (lane_empty[l])
            );
        end
    endgenerate

    assign last_warp = &lane_empty;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    pc_q <= '0;
        else if (load) pc_q <= in_pc;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_nx = (|in_mask) ? ST_EMIT : ST_NULL;
            ST_EMIT: if (out_ready && last_warp) state_nx = ST_IDLE;
            ST_NULL: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready = 1'b1;
            ST_EMIT: begin
                out_valid = 1'b1;
                done      = last_warp;
            end
            ST_NULL: done = 1'b1;
            default: ;
        endcase
    end

    assign load    = in_valid && in_ready;
    assign advance = out_valid && out_ready;
    assign out_pc  = pc_q;
endmodule

// File: rtl/tc_chk.sv
module tc_chk #(
    parameter int LANES = 4,
    parameter int ROWS  = 3,
    parameter int PCW   = 32,
    localparam int NTHR = LANES * ROWS,
    localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic [NTHR-1:0]       in_mask,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [PCW-1:0]        out_pc,
    input logic [LANES*TIDW-1:0] out_tid,
    input logic [LANES-1:0]      out_lane_vld,
    input logic                  done
);
    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_chk
            AST_LANE_BIND: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid && out_lane_vld[l] |-> (int'(out_tid[l*TIDW +: TIDW]) % LANES) == l); // R2
            AST_LANE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
                $past(out_valid && out_ready && out_lane_vld[l]) && out_valid && out_lane_vld[l]
                |-> out_tid[l*TIDW +: TIDW] > $past(out_tid[l*TIDW +: TIDW])); // R3
        end
    endgenerate

    AST_SOME_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> |out_lane_vld); // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_tid) && $stable(out_lane_vld) && $stable(out_pc)); // R6
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && done |=> !out_valid); // R7
    AST_NULL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done && !out_valid |-> $past(in_valid && in_ready && (in_mask == '0))); // R8
    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R10
    AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(out_valid) |-> $stable(out_pc)); // R11
endmodule

bind blk_thread_compactor tc_chk #(.LANES(LANES), .ROWS(ROWS), .PCW(PCW)) u_chk (.*);

// File: tb/sim_blk_thread_compactor.sv
module sim_blk_thread_compactor;
    localparam int L = 4;
    localparam int RW = 3;
    localparam int NT = L * RW;
    localparam int TW = $clog2(NT);
    localparam int PW = 16;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready;
    logic [NT-1:0] in_mask = '0;
    logic [PW-1:0] in_pc = '0;
    logic out_valid, out_ready = 1'b0, done;
    logic [PW-1:0] out_pc;
    logic [L*TW-1:0] out_tid;
    logic [L-1:0] out_lane_vld;

    int total = 0, bad = 0;
    bit wd_fired = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_thread_compactor #(.LANES(L), .ROWS(RW), .PCW(PW)) u0 (.*);

    task automatic chk(input bit ok, input string req, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic int max_occ(input logic [NT-1:0] m);
        int best = 0;
        for (int l = 0; l < L; l++) begin
            int c = 0;
            for (int r = 0; r < RW; r++) c += int'(m[r*L+l]);
            if (c > best) best = c;
        end
        return best;
    endfunction

    task automatic run_mask(input logic [NT-1:0] m, input logic [PW-1:0] pc,
                            input bit junk, input bit full_chk);
        logic [NT-1:0] rem = m;
        int n = max_occ(m);
        int got = 0;
        int guard = 0;
        @(negedge clk);
        in_mask = m; in_pc = pc; in_valid = 1'b1; out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = junk && (n > 0);
        in_mask = ~m; in_pc = ~pc;
        if (n == 0) begin
            chk(done && !out_valid, "R8", $sformatf("done=%0b out_valid=%0b exp 1/0", done, out_valid));
            @(negedge clk);
            chk(!done && in_ready && !out_valid, "R8",
                $sformatf("done=%0b in_ready=%0b exp 0/1", done, in_ready));
            return;
        end
        while (out_valid && guard < 400) begin
            logic [L-1:0] ev;
            logic [L*TW-1:0] et;
            logic [NT-1:0] nxt;
            bit rdy, tid_ok;
            guard++;
            ev = '0; et = '0; nxt = rem;
            for (int l = 0; l < L; l++)
                for (int r = 0; r < RW; r++)
                    if (!ev[l] && rem[r*L+l]) begin
                        ev[l] = 1'b1;
                        et[l*TW +: TW] = TW'(r*L+l);
                        nxt[r*L+l] = 1'b0;
                    end
            tid_ok = 1'b1;
            for (int l = 0; l < L; l++)
                if (ev[l] && out_tid[l*TW +: TW] != et[l*TW +: TW]) tid_ok = 1'b0;
            chk(tid_ok && out_lane_vld == ev, "R3",
                $sformatf("tid=%h vld=%b exp tid=%h vld=%b", out_tid, out_lane_vld, et, ev));
            chk(out_pc == pc, "R11", $sformatf("pc=%h exp %h", out_pc, pc));
            chk(done == (nxt == '0), "R7", $sformatf("done=%0b exp %0b", done, nxt == '0));
            chk(!in_ready, "R10", $sformatf("in_ready=%0b exp 0", in_ready));
            if (full_chk) begin
                bit f_ok = (out_lane_vld == '1);
                for (int l = 0; l < L; l++)
                    if (out_tid[l*TW +: TW] != TW'(got*L+l)) f_ok = 1'b0;
                chk(f_ok, "R9", $sformatf("warp %0d tid=%h vld=%b", got, out_tid, out_lane_vld));
            end
            rdy = ($urandom % 4) != 0;
            out_ready = rdy;
            if (rdy && nxt == '0) in_valid = 1'b0;
            @(posedge clk);
            if (rdy) begin rem = nxt; got++; end
            @(negedge clk);
            out_ready = 1'b0;
            in_valid = junk && (rem != '0);
        end
        in_valid = 1'b0;
        chk(got == n, "R4", $sformatf("warps=%0d exp %0d", got, n));
        chk(in_ready && !out_valid && !done, "R7",
            $sformatf("after run in_ready=%0b out_valid=%0b exp 1/0", in_ready, out_valid));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        wd_fired = 1'b1;
        total++; bad++;
        $display("FAIL watchdog: run did not finish, exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready && !out_valid && !done, "R1",
            $sformatf("in_ready=%0b out_valid=%0b done=%0b exp 1/0/0", in_ready, out_valid, done));
        rst_n = 1'b1;
        // spread example: threads 0,1,4,6,7,10,11 -> (0,1,6,7) then (4,-,10,11)
        run_mask(12'b1100_1101_0011, 16'h1A00, 1'b0, 1'b0);
        run_mask('1, 16'h2B00, 1'b0, 1'b1);            // R9 full mask
        run_mask('0, 16'h3C00, 1'b0, 1'b0);            // R8 empty
        run_mask(12'b1000_0000_0000, 16'h4D00, 1'b0, 1'b0); // R5 one slot only
        run_mask(12'b0001_0001_0001, 16'h5E00, 1'b1, 1'b0); // R10 lane heavy, busy offer
        run_mask('0, 16'h6F00, 1'b1, 1'b0);            // R8 back to back
        for (int i = 0; i < 40; i++) begin
            logic [NT-1:0] m = NT'($urandom);
            if (i % 7 == 3) m = m & NT'($urandom);
            run_mask(m, PW'($urandom), (i % 3) == 0, 1'b0);
        end
        if (!wd_fired) begin
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule